// File: doc/BRIEF.md
# LFSR Cycle-Length Measurement Unit

This block measures the cycle length of a configurable linear feedback shift register of 2 to 16 bits. On a start pulse it latches the register length, tap mask, feedback form and seed. It then loads the seed into an internal register and advances that register once per clock, counting steps, until the state matches the seed again. It reports the step count as the period, together with the state it stopped on and a flag saying whether the period reached the largest possible value, 2^n-1. That flag is how the caller learns whether a tap set is primitive.

A seed that is zero within the selected length can never leave zero, so the block rejects it at once. A tap set whose register never returns to its seed is stopped by a step limit. In both cases the error output is raised. A one-cycle done strobe ends every run. Busy covers the time the block is occupied and cannot take a new start.

Top module: `lfsr_period_detect`

## Requirements
- R1: After reset, busy, done, error and maximal are 0, and period and final state read 0.
- R2: On success, period equals the number of steps taken until the register first equals the latched seed again, and the final state output equals that seed.
- R3: With mode 0 (external XOR form), one step shifts the n-bit state right by one and writes the XOR of bit 0 and of every state bit i whose tap mask bit i is set into bit n-1. Tap mask bit i stands for tap position i+1.
- R4: With mode 1 (internal XOR form), one step shifts the n-bit state right by one and then XORs the tap mask into it when the bit shifted out was 1. Example: n=16, mask 0xB400, seed 0xACE1 gives period 65535.
- R5: Maximal is 1 exactly when the run succeeds with period equal to 2^n-1. Example: n=8, mode 0, mask 0x008C (taps 3,4,8) gives 255 with maximal set for any nonzero seed. Smaller tap sets give periods as short as 2 or 3.
- R6: A start whose seed is zero in its low n bits is refused. Done and error are 1 in the first cycle after the start edge, period is 0, and busy never rises.
- R7: If the step count reaches 2^n without the state matching the seed, the run ends with error 1, period 0 and maximal 0.
- R8: Busy is 1 from the cycle after the accepted start until the run ends. Done is high for exactly one cycle, and busy is 0 while done is high.
- R9: A start pulse while busy is ignored. Length, mask, mode and seed are sampled only at the accepted start, so input changes during a run do not alter its result.
- R10: For a primitive tap set, different nonzero seeds give the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| len_i | input | 5 | Register length n, 2 to 16 |
| taps_i | input | 16 | Tap mask, bit i = tap position i+1 |
| mode_i | input | 1 | 0 external XOR form, 1 internal XOR form |
| seed_i | input | 16 | Starting state, low n bits used |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| error_o | output | 1 | Zero seed or step limit reached |
| maximal_o | output | 1 | Period equals 2^n-1 |
| period_o | output | 17 | Measured period, 0 on error |
| final_o | output | 16 | State at the end of the run |

## Verification
Primitive tap sets are run in both feedback forms at 2, 8 and 16 bits, which separates a correct period count from an off-by-one count and tests the maximal comparison at both size extremes. Non-primitive sets with periods 2, 4 and 6 confirm that the flag stays clear for short cycles and that each form wires its taps in the right place. A mask that never returns to its seed, a zero seed, and a start given mid-run separate the two error exits from each other and from the ignored-start case. Three different seeds on one primitive set show that the period does not depend on the seed.

// File: rtl/lfsr_pd_pkg.sv
package lfsr_pd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } pd_state_e;

  typedef enum logic {
    MODE_FIB = 1'b0,
    MODE_GAL = 1'b1
  } pd_mode_e;
endpackage

// File: rtl/lfsr_pd_step.sv
module lfsr_pd_step #(
  parameter int W     = 16,
  parameter int LEN_W = 5
) (
  input  logic [LEN_W-1:0] len,
  input  logic [W-1:0]     taps,
  input  logic             mode,
  input  logic [W-1:0]     cur,
  output logic [W-1:0]     nxt
);
  logic [W-1:0] wmask;
  logic [W-1:0] top_bit;
  logic [W-1:0] shifted;
  logic [W-1:0] fib_nxt;
  logic [W-1:0] gal_nxt;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign wmask[i] = (len > LEN_W'(i));
  end

  always_comb begin
    top_bit = wmask ^ (wmask >> 1);
    shifted = (cur & wmask) >> 1;
    fb      = ^(cur & wmask & (taps | {{(W-1){1'b0}}, 1'b1}));
    fib_nxt = shifted | ({W{fb}} & top_bit);
    gal_nxt = shifted ^ ({W{cur[0]}} & taps);
    nxt     = ((mode == lfsr_pd_pkg::MODE_GAL) ? gal_nxt : fib_nxt) & wmask;
  end
endmodule

// File: rtl/lfsr_pd_ctrl.sv
module lfsr_pd_ctrl
  import lfsr_pd_pkg::*;
(
  input  pd_state_e st,
  input  logic      start,
  input  logic      seed_zero,
  input  logic      hit,
  input  logic      limit,
  output pd_state_e st_nxt
);
  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE: if (start) st_nxt = seed_zero ? ST_DONE : ST_LOAD;
      ST_LOAD: st_nxt = ST_RUN;
      ST_RUN:  if (hit || limit) st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lfsr_period_detect.sv
module lfsr_period_detect
  import lfsr_pd_pkg::*;
#(
  parameter int MAX_N = 16,
  localparam int W     = MAX_N,
  localparam int LEN_W = $clog2(MAX_N + 1),
  localparam int CNT_W = MAX_N + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [W-1:0]     taps_i,
  input  logic             mode_i,
  input  logic [W-1:0]     seed_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             maximal_o,
  output logic [CNT_W-1:0] period_o,
  output logic [W-1:0]     final_o
);
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pd_state_e        st_q, st_d;
  logic [LEN_W-1:0] len_q;
  logic [W-1:0]     taps_q, seed_q, lfsr_q, step_nxt, in_mask;
  logic             mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, lim, full;
  logic [CNT_W-1:0] period_q;
  logic             max_q, err_q;
  logic [W-1:0]     fin_q;
  logic             cap_en, seed_zero, hit, limit, run_end, zero_start;

  for (genvar i = 0; i < W; i++) begin : g_in_mask
    assign in_mask[i] = (len_i > LEN_W'(i));
  end

  always_comb begin
    seed_zero  = ((seed_i & in_mask) == '0);
    cap_en     = (st_q == ST_IDLE) && start_i;
    zero_start = cap_en && seed_zero;
    cnt_inc    = cnt_q + CNT_W'(1);
    lim        = CNT_W'(1) << len_q;
    full       = lim - CNT_W'(1);
    hit        = (step_nxt == seed_q);
    limit      = (cnt_inc == lim);
    run_end    = (st_q == ST_RUN) && (hit || limit);
  end

  lfsr_pd_step #(.W(W), .LEN_W(LEN_W)) u_step (
    .len  (len_q),
    .taps (taps_q),
    .mode (mode_q),
    .cur  (lfsr_q),
    .nxt  (step_nxt)
  );

  lfsr_pd_ctrl u_ctrl (
    .st        (st_q),
    .start     (start_i),
    .seed_zero (seed_zero),
    .hit       (hit),
    .limit     (limit),
    .st_nxt    (st_d)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      len_q  <= '0;
      taps_q <= '0;
      mode_q <= 1'b0;
      seed_q <= '0;
    end else if (cap_en) begin
      len_q  <= len_i;
      taps_q <= taps_i;
      mode_q <= mode_i;
      seed_q <= seed_i & in_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lfsr_q <= '0;
      cnt_q  <= '0;
    end else if (st_q == ST_LOAD) begin
      lfsr_q <= seed_q;
      cnt_q  <= '0;
    end else if (st_q == ST_RUN) begin
      lfsr_q <= step_nxt;
      cnt_q  <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      period_q <= '0;
      max_q    <= 1'b0;
      err_q    <= 1'b0;
      fin_q    <= '0;
    end else if (zero_start) begin
      period_q <= '0;
      max_q    <= 1'b0;
      err_q    <= 1'b1;
      fin_q    <= '0;
    end else if (run_end) begin
      period_q <= hit ? cnt_inc : '0;
      max_q    <= hit && (cnt_inc == full);
      err_q    <= !hit;
      fin_q    <= step_nxt;
    end
  end

  assign busy_o    = (st_q == ST_LOAD) || (st_q == ST_RUN);
  assign done_o    = (st_q == ST_DONE);
  assign error_o   = err_q;
  assign maximal_o = max_q;
  assign period_o  = period_q;
  assign final_o   = fin_q;
endmodule

// File: rtl/lfsr_period_detect_chk.sv
module lfsr_period_detect_chk #(
  parameter int W     = 16,
  parameter int LEN_W = 5,
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len_in,
  input logic [W-1:0]     seed_in,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic             maximal,
  input logic [CNT_W-1:0] period,
  input logic [W-1:0]     final_state,
  input logic [LEN_W-1:0] cfg_len,
  input logic [W-1:0]     cfg_seed
);
  logic [W-1:0] in_mask;
  for (genvar i = 0; i < W; i++) begin : g_m
    assign in_mask[i] = (len_in > LEN_W'(i));
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_len) && $stable(cfg_seed)));

  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && ((seed_in & in_mask) == '0)) |=> (done && error && !busy));

  // R5
  max_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && maximal) |-> (period == ((CNT_W'(1) << cfg_len) - CNT_W'(1))));

  // R7
  err_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (period == '0 && !maximal));

  // R2
  final_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (final_state == cfg_seed));
endmodule

bind lfsr_period_detect lfsr_period_detect_chk #(
  .W(W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start       (start_i),
  .len_in      (len_i),
  .seed_in     (seed_i),
  .busy        (busy_o),
  .done        (done_o),
  .error       (error_o),
  .maximal     (maximal_o),
  .period      (period_o),
  .final_state (final_o),
  .cfg_len     (len_q),
  .cfg_seed    (seed_q)
);

// File: tb/tb_lfsr_period_detect.sv
module tb_lfsr_period_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  len_i;
  logic [15:0] taps_i;
  logic        mode_i;
  logic [15:0] seed_i;
  logic        busy_o, done_o, error_o, maximal_o;
  logic [16:0] period_o;
  logic [15:0] final_o;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  lfsr_period_detect dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .taps_i(taps_i), .mode_i(mode_i), .seed_i(seed_i), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o), .maximal_o(maximal_o),
    .period_o(period_o), .final_o(final_o)
  );

  typedef struct packed {
    logic [4:0]  len;
    logic [15:0] taps;
    logic        mode;
    logic [15:0] seed;
    logic [16:0] per;
    logic        mx;
    logic        er;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'd8,  16'h008C, 1'b0, 16'd225,  17'd255,   1'b1, 1'b0}, // R3 R5
    '{5'd8,  16'h008C, 1'b0, 16'd1,    17'd255,   1'b1, 1'b0}, // R10
    '{5'd8,  16'h008C, 1'b0, 16'h005A, 17'd255,   1'b1, 1'b0}, // R10
    '{5'd2,  16'h0002, 1'b0, 16'd1,    17'd3,     1'b1, 1'b0}, // R5 n=2
    '{5'd2,  16'h0000, 1'b0, 16'd2,    17'd2,     1'b0, 1'b0}, // R5 period 2
    '{5'd4,  16'h000A, 1'b0, 16'd1,    17'd6,     1'b0, 1'b0}, // R3 non-primitive
    '{5'd4,  16'h0008, 1'b1, 16'd1,    17'd4,     1'b0, 1'b0}, // R4 non-primitive
    '{5'd4,  16'h0000, 1'b1, 16'd1,    17'd0,     1'b0, 1'b1}, // R7 never returns
    '{5'd16, 16'hB400, 1'b1, 16'hACE1, 17'd65535, 1'b1, 1'b0}, // R4 R5
    '{5'd8,  16'h008C, 1'b0, 16'h0100, 17'd0,     1'b0, 1'b1}  // R6 zero in low bits
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one run; returns cycles from the negedge after start until done.
  task automatic run(input vec_t v, output int waits);
    @(negedge clk);
    len_i = v.len; taps_i = v.taps; mode_i = v.mode; seed_i = v.seed;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waits = 0;
    while (!done_o && waits < 70000) begin
      @(negedge clk);
      waits++;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w;
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; taps_i = '0; mode_i = 1'b0; seed_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !error_o && !maximal_o, "R1 flags", {busy_o, done_o, error_o, maximal_o}, 0);
    check(period_o == 0 && final_o == 0, "R1 outputs", period_o, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], w);
      check(done_o == 1'b1, "R8 done seen", done_o, 1);
      check(period_o == VEC[i].per, "R2 period", period_o, VEC[i].per);
      check(maximal_o == VEC[i].mx, "R5 maximal", maximal_o, VEC[i].mx);
      check(error_o == VEC[i].er, "R7 error", error_o, VEC[i].er);
      check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
      if (!VEC[i].er)
        check(final_o == VEC[i].seed, "R2 final state", final_o, VEC[i].seed);
      if (VEC[i].seed[7:0] == 8'h00 && VEC[i].len == 5'd8)
        check(w == 0, "R6 immediate refusal", w, 0);
      else if (VEC[i].er)
        check(w == (1 << VEC[i].len) + 1, "R7 abort timing", w, (1 << VEC[i].len) + 1);
      else
        check(w == VEC[i].per + 1, "R8 run length", w, VEC[i].per + 1);
      @(negedge clk);
      check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    end

    // R6 plain zero seed: busy never rises
    @(negedge clk);
    len_i = 5'd4; taps_i = 16'h000A; mode_i = 1'b0; seed_i = 16'h0000; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o && error_o && !busy_o, "R6 zero seed", {done_o, error_o, busy_o}, 6);
    check(period_o == 0, "R6 period zero", period_o, 0);
    @(negedge clk);

    // R9 start while busy ignored, inputs changed mid-run
    @(negedge clk);
    len_i = 5'd8; taps_i = 16'h008C; mode_i = 1'b0; seed_i = 16'd77; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    repeat (5) @(negedge clk);
    len_i = 5'd4; taps_i = 16'h0008; mode_i = 1'b1; seed_i = 16'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    w = 0;
    while (!done_o && w < 1000) begin
      @(negedge clk);
      w++;
    end
    check(period_o == 255 && maximal_o, "R9 busy start ignored", period_o, 255);
    check(final_o == 16'd77, "R9 seed held", final_o, 77);
    @(negedge clk);
    check(!busy_o && !done_o, "R9 back to idle", {busy_o, done_o}, 0);

    // R1 reset mid-run clears everything
    run(VEC[5], w);
    @(negedge clk);
    len_i = 5'd8; taps_i = 16'h008C; mode_i = 1'b0; seed_i = 16'd9; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o && period_o == 0 && !error_o, "R1 reset mid-run", busy_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule